// File: doc/BRIEF.md
# ADC Bridge Power-Up Sequencer

This block brings an external 24-bit bridge-sensor converter from reset to a configured, running state without software help. A single start pulse launches a fixed series of byte register accesses. The series is a register reset, a digital power-up, a timed settling wait and a readiness check, then the power and supply configuration, the converter control setup, an optional regulator voltage setting and an optional rate setting. The accesses go out over an abstract register port made of a request pulse, write enable, address, write data, read data, a done strobe and an error strobe. Whatever bus carries them lies outside this block.

The regulator voltage, given in millivolts, is captured at the start pulse and decides two things. It decides whether the internal supply-select bit is set, and it supplies the 3-bit regulator code that is written when that supply is in use. A polling-mode flag, also captured at start, adds a final write that selects the fastest conversion rate. Busy, ready and error flags report progress. Ready rises only after every step has been acknowledged. Error rises when the readiness check fails or when the port reports an error.

Top module: `adc_pwrup_seq`

## Requirements
- R1: After reset, busy_o, ready_o, error_o and bus_req_o are all 0.
- R2: Each access is a single-cycle bus_req_o pulse. bus_we_o, bus_addr_o and bus_wdata_o are held until that access ends with bus_done_i or bus_err_i, and a new request is issued only after the previous access has ended.
- R3: The first access writes 0x01 to address 0x00 (register reset). The second writes 0x02 to address 0x00 (digital power-up).
- R4: The third access reads address 0x00. Its request comes no earlier than WAIT_US microseconds after the done of the power-up write, measured as WAIT_US*CLK_HZ/1e6 clock cycles.
- R5: If bit 3 of the byte read in R4 is 0, the sequence stops with no further access, error_o is 1 and ready_o is 0.
- R6: The fourth access writes 0x16 to address 0x00 (bits 1, 2 and 4). Bit 7 (0x80) is added when the captured millivolt value is 2400 or more.
- R7: The fifth access writes 0x30 to address 0x15.
- R8: When the captured millivolt value is 2400 or more, a write to address 0x01 follows with the value code<<3, where code = (4500 - mV)/300 (code 0 at 4500 mV and above). Below 2400 mV this write is skipped.
- R9: When the captured polling flag is 1, the last access writes 0x70 to address 0x02 (rate code 7 in bits 6:4). Otherwise this write is skipped.
- R10: bus_err_i during an access ends the sequence at once. On the next cycle error_o is 1 and busy_o is 0, and no further request follows. The error wins when done and error arrive in the same cycle.
- R11: On the cycle after the final access's done, busy_o falls and ready_o rises. At most one of busy_o, ready_o and error_o is 1 at any time. The flags hold until the next accepted start, which clears ready_o and error_o.
- R12: A start pulse while busy_o is 1 is ignored, including one that falls on the final done cycle. ldo_mv_i and poll_mode_i are only sampled when a start is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse |
| ldo_mv_i | input | MV_W | Regulator voltage in millivolts |
| poll_mode_i | input | 1 | Polling mode: add the rate write |
| bus_req_o | output | 1 | Access request pulse |
| bus_we_o | output | 1 | 1 = write, 0 = read |
| bus_addr_o | output | ADDR_W | Register address |
| bus_wdata_o | output | DATA_W | Write data |
| bus_rdata_i | input | DATA_W | Read data, valid with bus_done_i |
| bus_done_i | input | 1 | Access completed |
| bus_err_i | input | 1 | Access failed |
| busy_o | output | 1 | Sequence in progress |
| ready_o | output | 1 | Sequence completed |
| error_o | output | 1 | Sequence aborted |

## Verification
Two events can coincide. The first is a new start pulse landing on the cycle in which the last access is acknowledged. The bench drives start together with that final done strobe and then expects ready, no second sequence and no new request. The second is the port raising done and error in the same cycle. The bench injects both at once on a chosen access and expects the error path: the transaction log is cut at that access and error is set without ready. Random runs mix these collisions with random latencies, voltages, status bytes and mid-sequence start pulses, and every run is compared against a transaction list computed from the requirements.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 8;

  localparam logic [ADDR_W-1:0] A_PWR   = 8'h00;
  localparam logic [ADDR_W-1:0] A_GAINV = 8'h01;
  localparam logic [ADDR_W-1:0] A_RATE  = 8'h02;
  localparam logic [ADDR_W-1:0] A_ADCC  = 8'h15;

  localparam logic [DATA_W-1:0] V_RESET  = 8'h01;
  localparam logic [DATA_W-1:0] V_DPWR   = 8'h02;
  localparam logic [DATA_W-1:0] V_RUN    = 8'h16;
  localparam logic [DATA_W-1:0] V_ADCC   = 8'h30;
  localparam logic [DATA_W-1:0] V_RATE   = 8'h70;
  localparam int               RDY_BIT  = 3;
  localparam int               SUPPLY_BIT = 7;
  localparam int               LDO_LSB  = 3;

  localparam int HI_SUPPLY_MV = 2400;
  localparam int LDO_TOP_MV   = 4500;
  localparam int LDO_STEP_MV  = 300;

  typedef enum logic [3:0] {
    ST_IDLE, ST_RST, ST_PUD, ST_WAIT, ST_CHK,
    ST_RUN, ST_ADCC, ST_LDO, ST_RATE
  } seq_state_t;
endpackage

// File: rtl/adc_seq_timer.sv
module adc_seq_timer #(
  parameter int CNT_MAX = 42000,
  localparam int CW = $clog2(CNT_MAX + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic en,
  output logic hit
);
  logic [CW-1:0] cnt;

  assign hit = (cnt == CW'(CNT_MAX - 1));

  always_ff @(posedge clk) begin
    if (rst || clr)
      cnt <= '0;
    else if (en && !hit)
      cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/adc_seq_cfg.sv
module adc_seq_cfg
  import adc_seq_pkg::*;
#(
  parameter int MV_W = 13
) (
  input  logic [MV_W-1:0]   mv,
  output logic              hi_supply,
  output logic [DATA_W-1:0] run_byte,
  output logic [DATA_W-1:0] ldo_byte
);
  int unsigned mv_u;
  logic [2:0]  code;

  always_comb begin
    mv_u      = int'(mv);
    hi_supply = (mv_u >= HI_SUPPLY_MV);
    if (mv_u >= LDO_TOP_MV)
      code = 3'd0;
    else
      code = 3'((LDO_TOP_MV - mv_u) / LDO_STEP_MV);
    run_byte = V_RUN;
    run_byte[SUPPLY_BIT] = hi_supply;
    ldo_byte = '0;
    ldo_byte[LDO_LSB +: 3] = code;
  end
endmodule

// File: rtl/adc_pwrup_seq.sv
module adc_pwrup_seq
  import adc_seq_pkg::*;
#(
  parameter int CLK_HZ  = 200_000_000,
  parameter int WAIT_US = 210,
  parameter int MV_W    = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [MV_W-1:0]   ldo_mv_i,
  input  logic              poll_mode_i,
  output logic              bus_req_o,
  output logic              bus_we_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [DATA_W-1:0] bus_wdata_o,
  input  logic [DATA_W-1:0] bus_rdata_i,
  input  logic              bus_done_i,
  input  logic              bus_err_i,
  output logic              busy_o,
  output logic              ready_o,
  output logic              error_o
);
  localparam int WAIT_CYC = (CLK_HZ / 1_000_000) * WAIT_US;

  seq_state_t        state, nxt;
  logic              nxt_fail;
  logic              issued;
  logic [MV_W-1:0]   mv_q;
  logic              poll_q;
  logic              hi_supply;
  logic [DATA_W-1:0] run_byte, ldo_byte;
  logic              acc_we;
  logic [ADDR_W-1:0] acc_addr;
  logic [DATA_W-1:0] acc_wdata;
  logic              t_clr, t_hit;

  adc_seq_cfg #(.MV_W(MV_W)) u_cfg (
    .mv(mv_q), .hi_supply(hi_supply), .run_byte(run_byte), .ldo_byte(ldo_byte)
  );

  assign t_clr = (state == ST_PUD) && issued && bus_done_i && !bus_err_i;

  adc_seq_timer #(.CNT_MAX(WAIT_CYC)) u_tmr (
    .clk(clk), .rst(rst), .clr(t_clr), .en(state == ST_WAIT), .hit(t_hit)
  );

  // access contents per step
  always_comb begin
    acc_we = 1'b1; acc_addr = A_PWR; acc_wdata = '0;
    unique case (state)
      ST_RST:  acc_wdata = V_RESET;
      ST_PUD:  acc_wdata = V_DPWR;
      ST_CHK:  acc_we = 1'b0;
      ST_RUN:  acc_wdata = run_byte;
      ST_ADCC: begin acc_addr = A_ADCC;  acc_wdata = V_ADCC;   end
      ST_LDO:  begin acc_addr = A_GAINV; acc_wdata = ldo_byte; end
      ST_RATE: begin acc_addr = A_RATE;  acc_wdata = V_RATE;   end
      default: ;
    endcase
  end

  // step following a completed access
  always_comb begin
    nxt = ST_IDLE; nxt_fail = 1'b0;
    unique case (state)
      ST_RST:  nxt = ST_PUD;
      ST_PUD:  nxt = ST_WAIT;
      ST_CHK:  begin
        if (bus_rdata_i[RDY_BIT]) nxt = ST_RUN;
        else nxt_fail = 1'b1;
      end
      ST_RUN:  nxt = ST_ADCC;
      ST_ADCC: nxt = hi_supply ? ST_LDO : (poll_q ? ST_RATE : ST_IDLE);
      ST_LDO:  nxt = poll_q ? ST_RATE : ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE; issued <= 1'b0;
      bus_req_o <= 1'b0; bus_we_o <= 1'b0;
      bus_addr_o <= '0; bus_wdata_o <= '0;
      busy_o <= 1'b0; ready_o <= 1'b0; error_o <= 1'b0;
      mv_q <= '0; poll_q <= 1'b0;
    end else begin
      bus_req_o <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start_i) begin
            state <= ST_RST; issued <= 1'b0;
            busy_o <= 1'b1; ready_o <= 1'b0; error_o <= 1'b0;
            mv_q <= ldo_mv_i; poll_q <= poll_mode_i;
          end
        end
        ST_WAIT: begin
          if (t_hit) state <= ST_CHK;
        end
        default: begin
          if (!issued) begin
            bus_req_o <= 1'b1; issued <= 1'b1;
            bus_we_o <= acc_we; bus_addr_o <= acc_addr; bus_wdata_o <= acc_wdata;
          end else if (bus_err_i) begin
            state <= ST_IDLE; issued <= 1'b0;
            busy_o <= 1'b0; error_o <= 1'b1;
          end else if (bus_done_i) begin
            state <= nxt; issued <= 1'b0;
            if (nxt == ST_IDLE) begin
              busy_o  <= 1'b0;
              ready_o <= !nxt_fail;
              error_o <= nxt_fail;
            end
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/adc_pwrup_seq_chk.sv
module adc_pwrup_seq_chk
  import adc_seq_pkg::*;
#(
  parameter int CLK_HZ  = 200_000_000,
  parameter int WAIT_US = 210
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_req_o,
  input logic              bus_we_o,
  input logic [ADDR_W-1:0] bus_addr_o,
  input logic [DATA_W-1:0] bus_wdata_o,
  input logic              bus_done_i,
  input logic              bus_err_i,
  input logic              busy_o,
  input logic              ready_o,
  input logic              error_o
);
  localparam int WAIT_CYC = (CLK_HZ / 1_000_000) * WAIT_US;

  logic        pend, pud_pend;
  logic [31:0] wcnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend <= 1'b0; pud_pend <= 1'b0; wcnt <= '0;
    end else begin
      if (bus_req_o) begin
        pend <= 1'b1;
        pud_pend <= bus_we_o && bus_addr_o == A_PWR && bus_wdata_o == V_DPWR;
      end else if (bus_done_i || bus_err_i) begin
        pend <= 1'b0; pud_pend <= 1'b0;
      end
      if (pend && pud_pend && bus_done_i) wcnt <= '0;
      else if (wcnt != 32'hFFFF_FFFF) wcnt <= wcnt + 1;
    end
  end

  a_r2_req_pulse: assert property (@(posedge clk) disable iff (rst)
    bus_req_o |=> !bus_req_o);
  a_r2_one_outstanding: assert property (@(posedge clk) disable iff (rst)
    bus_req_o |-> !pend);
  a_r2_hold_fields: assert property (@(posedge clk) disable iff (rst)
    (pend && !bus_req_o) |-> ($stable(bus_addr_o) && $stable(bus_we_o) && $stable(bus_wdata_o)));
  a_r4_wait_min: assert property (@(posedge clk) disable iff (rst)
    (bus_req_o && !bus_we_o) |-> (wcnt >= WAIT_CYC));
  a_r10_err_abort: assert property (@(posedge clk) disable iff (rst)
    (pend && bus_err_i) |=> (error_o && !busy_o && !ready_o));
  a_r11_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
    $countones({busy_o, ready_o, error_o}) <= 1);
  a_r11_ready_after_done: assert property (@(posedge clk) disable iff (rst)
    $rose(ready_o) |-> $past(bus_done_i && pend && !bus_err_i));
  a_r12_req_only_busy: assert property (@(posedge clk) disable iff (rst)
    bus_req_o |-> busy_o);
endmodule

bind adc_pwrup_seq adc_pwrup_seq_chk #(.CLK_HZ(CLK_HZ), .WAIT_US(WAIT_US)) u_chk (
  .clk(clk), .rst(rst), .bus_req_o(bus_req_o), .bus_we_o(bus_we_o),
  .bus_addr_o(bus_addr_o), .bus_wdata_o(bus_wdata_o), .bus_done_i(bus_done_i),
  .bus_err_i(bus_err_i), .busy_o(busy_o), .ready_o(ready_o), .error_o(error_o)
);

// File: tb/adc_pwrup_seq_test.sv
module adc_pwrup_seq_test;
  // 200 MHz clock; the counter is told a lower frequency to keep waits short
  localparam int CLK_HZ   = 20_000_000;
  localparam int WAIT_US  = 210;
  localparam int MV_W     = 13;
  localparam int WAIT_CYC = (CLK_HZ / 1_000_000) * WAIT_US;
  localparam int NO_ERR   = 99;

  logic clk = 1'b0, rst = 1'b1;
  logic start_a = 1'b0, start_b = 1'b0, start_i;
  logic [MV_W-1:0] ldo_mv_i = '0;
  logic poll_mode_i = 1'b0;
  logic bus_req_o, bus_we_o;
  logic [7:0] bus_addr_o, bus_wdata_o;
  logic [7:0] bus_rdata_i = '0;
  logic bus_done_i = 1'b0, bus_err_i = 1'b0;
  logic busy_o, ready_o, error_o;

  assign start_i = start_a | start_b;

  always #2.5 clk = ~clk;

  adc_pwrup_seq #(.CLK_HZ(CLK_HZ), .WAIT_US(WAIT_US), .MV_W(MV_W)) uut (
    .clk(clk), .rst(rst), .start_i(start_i), .ldo_mv_i(ldo_mv_i),
    .poll_mode_i(poll_mode_i), .bus_req_o(bus_req_o), .bus_we_o(bus_we_o),
    .bus_addr_o(bus_addr_o), .bus_wdata_o(bus_wdata_o), .bus_rdata_i(bus_rdata_i),
    .bus_done_i(bus_done_i), .bus_err_i(bus_err_i), .busy_o(busy_o),
    .ready_o(ready_o), .error_o(error_o)
  );

  int checks = 0, fails = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // responder settings and transaction log
  logic [7:0] status_byte = 8'h08;
  int err_at = NO_ERR, err_with_done = 0, start_on_idx = NO_ERR;
  int log_n = 0, t_done1 = 0, t_req2 = 0, run_base = 0;
  logic       log_we[512];
  logic [7:0] log_addr[512], log_data[512];

  initial begin
    forever begin
      @(negedge clk);
      if (bus_req_o) begin
        automatic int idx = log_n - run_base;
        log_we[log_n] = bus_we_o; log_addr[log_n] = bus_addr_o;
        log_data[log_n] = bus_wdata_o; log_n = log_n + 1;
        if (idx == 2) t_req2 = cyc;
        repeat ($urandom_range(1, 4)) @(negedge clk);
        bus_rdata_i = status_byte;
        if (idx == err_at) begin bus_err_i = 1'b1; bus_done_i = err_with_done[0]; end
        else bus_done_i = 1'b1;
        if (idx == start_on_idx) start_b = 1'b1;
        if (idx == 1) t_done1 = cyc;
        @(negedge clk);
        bus_done_i = 1'b0; bus_err_i = 1'b0; start_b = 1'b0;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // expected transaction list from the requirements
  logic       e_we[16];
  logic [7:0] e_addr[16], e_data[16];
  int e_n; bit e_err;
  task automatic build(input int mv, input bit poll, input logic [7:0] st, input int ea);
    int n = 0; bit hi = (mv >= 2400);
    int code = (mv >= 4500) ? 0 : (4500 - mv) / 300;
    e_err = 1'b0;
    e_we[n]=1; e_addr[n]=8'h00; e_data[n]=8'h01; n++;              // R3
    e_we[n]=1; e_addr[n]=8'h00; e_data[n]=8'h02; n++;              // R3
    e_we[n]=0; e_addr[n]=8'h00; e_data[n]=8'h00; n++;              // R4
    if (!st[3]) e_err = 1'b1;                                      // R5
    else begin
      e_we[n]=1; e_addr[n]=8'h00; e_data[n]=hi ? 8'h96 : 8'h16; n++; // R6
      e_we[n]=1; e_addr[n]=8'h15; e_data[n]=8'h30; n++;            // R7
      if (hi) begin e_we[n]=1; e_addr[n]=8'h01; e_data[n]=8'(code << 3); n++; end // R8
      if (poll) begin e_we[n]=1; e_addr[n]=8'h02; e_data[n]=8'h70; n++; end       // R9
    end
    if (ea < n) begin n = ea + 1; e_err = 1'b1; end                // R10
    e_n = n;
  endtask

  task automatic run(input int mv, input bit poll, input logic [7:0] st, input int ea,
                     input int ewd, input bit coll, input bit mid_start);
    int w = 0;
    build(mv, poll, st, ea);
    status_byte = st; err_at = ea; err_with_done = ewd;
    start_on_idx = coll ? e_n - 1 : NO_ERR;
    run_base = log_n;
    @(negedge clk);
    ldo_mv_i = MV_W'(mv); poll_mode_i = poll; start_a = 1'b1;
    @(negedge clk);
    start_a = 1'b0;
    ldo_mv_i = MV_W'($urandom_range(0, 8000)); poll_mode_i = ~poll;   // R12 capture
    if (mid_start) begin
      repeat (3) @(negedge clk);
      start_a = 1'b1; @(negedge clk); start_a = 1'b0;                 // R12 ignored
    end
    while (busy_o && w < 20000) begin @(negedge clk); w++; end
    chk(w < 20000, "R11 completion", w, 0);
    repeat (30) @(negedge clk);
    chk((log_n - run_base) == e_n, "R2 access count", log_n - run_base, e_n);
    for (int i = 0; i < e_n && i < log_n - run_base; i++) begin
      automatic int k = run_base + i;
      chk(log_we[k] == e_we[i] && log_addr[k] == e_addr[i] &&
          (!e_we[i] || log_data[k] == e_data[i]),
          i < 2 ? "R3 step" : i == 2 ? "R4 read" : i == 3 ? "R6 power write" :
          i == 4 ? "R7 control write" : "R8/R9 option write",
          {log_we[k], log_addr[k], log_data[k]}, {e_we[i], e_addr[i], e_data[i]});
    end
    chk(error_o == e_err && ready_o == !e_err && !busy_o, e_err ? "R10 error flag" : "R11 ready flag",
        {busy_o, ready_o, error_o}, {1'b0, !e_err, e_err});
    if (e_n >= 3 && ea >= 2)
      chk((t_req2 - t_done1) >= WAIT_CYC && (t_req2 - t_done1) <= WAIT_CYC + 3,
          "R4 wait length", t_req2 - t_done1, WAIT_CYC);
  endtask

  initial begin
    #(5.0 * 195000);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (4) @(negedge clk);
    chk(!busy_o && !ready_o && !error_o && !bus_req_o, "R1 reset state",
        {busy_o, ready_o, error_o, bus_req_o}, 0);
    rst = 1'b0;
    run(3300, 1, 8'h08, NO_ERR, 0, 0, 0);   // R8 code 4, R9 rate
    run(2400, 0, 8'hFF, NO_ERR, 0, 0, 1);   // R8 code 7, R12 mid start
    run(2399, 1, 8'h08, NO_ERR, 0, 0, 0);   // R6/R8 below threshold
    run(4500, 0, 8'h08, NO_ERR, 0, 0, 0);   // R8 code 0
    run(3000, 1, 8'hF7, NO_ERR, 0, 0, 0);   // R5 not ready
    run(3000, 1, 8'h08, 0, 0, 0, 0);        // R10 error first access
    run(3000, 1, 8'h08, 4, 1, 0, 0);        // R10 err with done
    run(2000, 1, 8'h08, NO_ERR, 0, 1, 0);   // R12 start on final done
    chk(!bus_req_o && ready_o && !busy_o, "R12 collision start ignored",
        {bus_req_o, ready_o, busy_o}, 3'b010);
    for (int r = 0; r < 14; r++) begin
      automatic int mv = $urandom_range(1800, 4700);
      automatic logic [7:0] st = 8'($urandom);
      automatic int ea = ($urandom_range(0, 3) == 0) ? $urandom_range(0, 7) : NO_ERR;
      if ($urandom_range(0, 4) != 0) st[3] = 1'b1;
      run(mv, 1'($urandom), st, ea, $urandom_range(0, 1), $urandom_range(0, 3) == 0,
          1'($urandom));
    end
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule